// File: doc/BRIEF.md
# Configurable Serial Audio Input Port

The block receives stereo PCM over a three-wire serial link (bit clock, word clock, serial data) and presents each stereo frame as a pair of parallel samples with a one-cycle valid strobe. Everything runs on one system clock. The serial clocks are either driven by the block or taken from an external source. In both cases they pass through the same synchronizer as the data. A bit is taken on each detected edge of the selected bit-clock polarity.

An 8-bit configuration word sets the framing: clock direction, frame length, justification, right-justified word length, the one-bit delay of left-justified data, the bit-clock edge and the word-clock polarity. When the block drives the clocks, the bit clock is a division of the system clock by a parameter, and the word clock toggles after a fixed number of bit periods. Samples narrower than the output width are aligned to the top of the output word, and the unused low bits read zero.

Top module: `sai_rx`

## Requirements
- R1: cfg_i[7] selects clocking. At 0 the external sclk_i/lrck_i are used and sclk_o/lrck_o stay 0. At 1 the block drives sclk_o with a period of 2*CLK_DIV system clocks and takes its bits from that clock.
- R2: cfg_i[6] sets the half-frame length: 32 bit periods at 0, 64 at 1. In driven mode lrck_o toggles every half-frame, on the edge opposite the sampling edge.
- R3: In right-justified mode, cfg_i[5:4] sets the word length: 0 gives 24 bits, 1 gives 20 bits, 2 or 3 give 16 bits.
- R4: cfg_i[3]=0 selects left-justified data and cfg_i[3]=1 selects right-justified data. Right-justified data ends with its LSB in the last bit period of the half-frame.
- R5: For left-justified data, cfg_i[2] places the MSB in the first (0) or second (1) bit period after the word-clock edge.
- R6: cfg_i[1] selects the sampling edge: rising edge of the bit clock at 0, falling edge at 1.
- R7: cfg_i[0]=0 maps word clock high to the left channel. cfg_i[0]=1 maps word clock high to the right channel.
- R8: A sample narrower than 24 bits appears MSB-aligned on left_o/right_o with zeros in the unused low bits. Bits outside the sample window are discarded.
- R9: valid_o pulses for exactly one cycle per frame, after the left and then the right channel are complete. left_o/right_o change only in that cycle.
- R10: After reset, left_o, right_o, valid_o, sclk_o and lrck_o are all 0.
- R11: In left-justified mode, cfg_i[5:4] has no effect and 24 bits are always captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 8 | Framing configuration word |
| sclk_i | input | 1 | External bit clock (used when cfg_i[7]=0) |
| lrck_i | input | 1 | External word clock (used when cfg_i[7]=0) |
| sdata_i | input | 1 | Serial data, MSB first |
| sclk_o | output | 1 | Generated bit clock (0 when cfg_i[7]=0) |
| lrck_o | output | 1 | Generated word clock (0 when cfg_i[7]=0) |
| left_o | output | DATA_W | Left sample, MSB-aligned |
| right_o | output | DATA_W | Right sample, MSB-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new frame |

## Verification
Each test drives distinct sample values per frame. Every bit outside the sample window is driven as 1, so an off-by-one window, a missing zero pad or a wrong word length shows up as set bits in the output. Left-justified framing is run with and without the delay bit, and once with a nonzero word-length field to show that the field is ignored. Right-justified framing is run at 24, 20 and 16 bits over both frame lengths. A falling-edge run with the channel swap set separates correct channel mapping from swapped data. The transmitter model moves data one system clock after the non-sampling edge, so sampling on the wrong edge picks up the previous bit. In the driven-clock run, the bench answers the generated clocks and measures their bit and half-frame periods.

// File: rtl/sai_pkg.sv
package sai_pkg;
  typedef struct packed {
    logic       master;
    logic       fs128;
    logic [1:0] res;
    logic       rjust;
    logic       dly;
    logic       fall;
    logic       lr_swap;
  } sai_cfg_t;
endpackage

// File: rtl/sai_clkgen.sv
module sai_clkgen #(
  parameter int CLK_DIV = 4,
  parameter int IDX_W   = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fs128_i,
  input  logic fall_i,
  output logic sclk_o,
  output logic lrck_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(CLK_DIV - 1);
  localparam logic [IDX_W-1:0] HALF_FULL = IDX_W'(1 << (IDX_W - 1));

  logic [CW-1:0]    div_q;
  logic [IDX_W-1:0] bit_q;
  logic [IDX_W-1:0] half_last;
  logic             ph_q, lr_q;

  assign half_last = (fs128_i ? HALF_FULL : (HALF_FULL >> 1)) - IDX_W'(1);

  // ph 0->1 is the sampling edge, 1->0 the launch edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      bit_q <= '0;
      ph_q  <= 1'b0;
      lr_q  <= 1'b0;
    end else if (!en_i) begin
      div_q <= '0;
      bit_q <= '0;
      ph_q  <= 1'b0;
      lr_q  <= 1'b0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      ph_q  <= ~ph_q;
      if (ph_q) begin
        if (bit_q == half_last) begin
          bit_q <= '0;
          lr_q  <= ~lr_q;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign sclk_o = en_i & (ph_q ^ fall_i);
  assign lrck_o = lr_q;
endmodule

// File: rtl/sai_sync_edge.sv
module sai_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic data_i,
  output logic strobe_o,
  output logic ws_o,
  output logic bit_o
);
  logic [2:0] last_s;
  logic       sclk_d_q;

  generate
    if (STAGES <= 1) begin : g_one
      logic [2:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {sclk_i, lrck_i, data_i};
      end
      assign last_s = pipe_q;
    end else begin : g_many
      logic [3*STAGES-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else         pipe_q <= {pipe_q[3*STAGES-4:0], sclk_i, lrck_i, data_i};
      end
      assign last_s = pipe_q[3*STAGES-1 -: 3];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= last_s[2];
  end

  assign strobe_o = fall_i ? (sclk_d_q & ~last_s[2]) : (~sclk_d_q & last_s[2]);
  assign ws_o     = last_s[1];
  assign bit_o    = last_s[0];
endmodule

// File: rtl/sai_deser.sv
module sai_deser #(
  parameter int DATA_W = 24,
  parameter int IDX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs128_i,
  input  logic [1:0]        res_i,
  input  logic              rjust_i,
  input  logic              dly_i,
  input  logic              lr_swap_i,
  input  logic              strobe_i,
  input  logic              ws_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  localparam int IW = IDX_W + 1;
  localparam logic [IW-1:0] HALF_FULL = IW'(1 << (IDX_W - 1));
  localparam logic [IW-1:0] DW = IW'(DATA_W);

  logic [IW-1:0]     half_len, width, start, stop, cur_ext;
  logic [IDX_W-1:0]  idx_q, cur_idx;
  logic              have_q, prev_q, synced_q, pend_q, valid_q;
  logic              trans, synced_n, in_win, done, is_left;
  logic [DATA_W-1:0] sh_q, sh_next, word, hold_q, left_q, right_q;

  assign half_len = fs128_i ? HALF_FULL : (HALF_FULL >> 1);
  always_comb begin
    if (!rjust_i)           width = DW;
    else if (res_i == 2'd0) width = DW;
    else if (res_i == 2'd1) width = DW - IW'(4);
    else                    width = DW - IW'(8);
  end
  assign start = rjust_i ? (half_len - width) : {{(IW-1){1'b0}}, dly_i};
  assign stop  = start + width - IW'(1);

  assign trans    = have_q && (ws_i != prev_q);
  assign synced_n = synced_q | trans;
  assign cur_idx  = trans ? '0 : ((&idx_q) ? idx_q : idx_q + 1'b1);
  assign cur_ext  = {1'b0, cur_idx};
  assign in_win   = synced_n && (cur_ext >= start) && (cur_ext <= stop);
  assign done     = in_win && (cur_ext == stop);
  assign sh_next  = {sh_q[DATA_W-2:0], bit_i};
  assign word     = sh_next << (DW - width);
  assign is_left  = ws_i ^ lr_swap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      have_q   <= 1'b0;
      prev_q   <= 1'b0;
      synced_q <= 1'b0;
      pend_q   <= 1'b0;
      valid_q  <= 1'b0;
      sh_q     <= '0;
      hold_q   <= '0;
      left_q   <= '0;
      right_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (strobe_i) begin
        have_q   <= 1'b1;
        prev_q   <= ws_i;
        idx_q    <= cur_idx;
        synced_q <= synced_n;
        if (in_win) sh_q <= sh_next;
        if (done) begin
          if (is_left) begin
            hold_q <= word;
            pend_q <= 1'b1;
          end else if (pend_q) begin
            left_q  <= hold_q;
            right_q <= word;
            valid_q <= 1'b1;
            pend_q  <= 1'b0;
          end
        end
      end
    end
  end

  assign left_o  = left_q;
  assign right_o = right_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/sai_rx.sv
module sai_rx
  import sai_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        cfg_i,
  input  logic              sclk_i,
  input  logic              lrck_i,
  input  logic              sdata_i,
  output logic              sclk_o,
  output logic              lrck_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              valid_o
);
  localparam int IDX_W = 7;

  sai_cfg_t cfg;
  logic     sclk_raw, lrck_raw, strobe, ws, dbit;

  assign cfg = cfg_i;

  sai_clkgen #(.CLK_DIV(CLK_DIV), .IDX_W(IDX_W)) clkgen_i (
    .clk_i, .rst_ni,
    .en_i(cfg.master), .fs128_i(cfg.fs128), .fall_i(cfg.fall),
    .sclk_o, .lrck_o
  );

  // generated clocks take the same sync path as external ones
  assign sclk_raw = cfg.master ? sclk_o : sclk_i;
  assign lrck_raw = cfg.master ? lrck_o : lrck_i;

  sai_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i, .rst_ni, .fall_i(cfg.fall),
    .sclk_i(sclk_raw), .lrck_i(lrck_raw), .data_i(sdata_i),
    .strobe_o(strobe), .ws_o(ws), .bit_o(dbit)
  );

  sai_deser #(.DATA_W(DATA_W), .IDX_W(IDX_W)) deser_i (
    .clk_i, .rst_ni,
    .fs128_i(cfg.fs128), .res_i(cfg.res), .rjust_i(cfg.rjust),
    .dly_i(cfg.dly), .lr_swap_i(cfg.lr_swap),
    .strobe_i(strobe), .ws_i(ws), .bit_i(dbit),
    .left_o, .right_o, .valid_o
  );
endmodule

// File: rtl/sai_rx_chk.sv
module sai_rx_chk #(
  parameter int DATA_W  = 24,
  parameter int CLK_DIV = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        cfg_i,
  input logic              sclk_o,
  input logic              lrck_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              valid_o
);
  logic [15:0] gap_q;
  logic        sclk_d_q;
  logic        toggled;

  assign toggled = sclk_o != sclk_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= '0;
      sclk_d_q <= 1'b0;
    end else begin
      sclk_d_q <= sclk_o;
      if (!cfg_i[7])    gap_q <= '0;
      else if (toggled) gap_q <= 16'd1;
      else              gap_q <= gap_q + 16'd1;
    end
  end

  p_sclk_rate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[7] && $past(cfg_i) == cfg_i && toggled) |-> gap_q == 16'(CLK_DIV));

  p_slave_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i[7] && !$past(cfg_i[7])) |-> (!sclk_o && !lrck_o));

  p_lrck_launch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[7] && $past(cfg_i) == cfg_i && lrck_o != $past(lrck_o))
      |-> (sclk_o == cfg_i[1] && sclk_o != $past(sclk_o)));

  p_pad_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_i[3] && cfg_i[5:4] != 2'd0)
      |-> (left_o[3:0] == 4'd0 && right_o[3:0] == 4'd0));

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_hold_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
endmodule

bind sai_rx sai_rx_chk #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_i(cfg_i), .sclk_o(sclk_o),
  .lrck_o(lrck_o), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/sai_rx_tb_top.sv
module sai_rx_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg = 8'h00;
  logic        sclk_i = 1'b0, lrck_i = 1'b0, sdata_i = 1'b0;
  logic        sclk_o, lrck_o, valid_o;
  logic [23:0] left_o, right_o;

  int n_chk = 0, n_bad = 0, ngot = 0;
  logic [23:0] got_l [8];
  logic [23:0] got_r [8];

  always #2 clk = ~clk;

  sai_rx #(.DATA_W(24), .CLK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .sclk_i(sclk_i), .lrck_i(lrck_i),
    .sdata_i(sdata_i), .sclk_o(sclk_o), .lrck_o(lrck_o), .left_o(left_o),
    .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o && ngot < 8) begin
      got_l[ngot] = left_o;
      got_r[ngot] = right_o;
      ngot++;
    end
  end

  function automatic logic [23:0] l_smp(int seed, int k);
    return 24'(seed * 977 + k * 32'h2F1D07 + 32'h5A3C96);
  endfunction
  function automatic logic [23:0] r_smp(int seed, int k);
    return 24'(seed * 3301 + k * 32'h1B3C5D + 32'h0F0F0F);
  endfunction
  function automatic int wid(logic [7:0] c);
    if (!c[3]) return 24;
    return (c[5:4] == 2'd0) ? 24 : (c[5:4] == 2'd1) ? 20 : 16;
  endfunction
  function automatic logic fbit(logic [23:0] s, int idx, logic [7:0] c);
    int n = c[6] ? 64 : 32;
    int w = wid(c);
    int st = c[3] ? n - w : int'(c[2]);
    if (idx >= st && idx < st + w) return s[23 - (idx - st)];
    return 1'b1;
  endfunction
  function automatic logic [23:0] expv(logic [23:0] s, logic [7:0] c);
    return s & (24'hFFFFFF << (24 - wid(c)));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] c);
    rst_n   = 1'b0;
    cfg     = c;
    sclk_i  = ~c[1];
    lrck_i  = c[0];
    sdata_i = 1'b0;
    ngot    = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(input logic [7:0] c, input logic ws, input logic b);
    @(negedge clk) sclk_i = c[1];
    @(negedge clk) begin lrck_i = ws; sdata_i = b; end
    @(negedge clk);
    @(negedge clk) sclk_i = ~c[1];
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frames(input string req, input logic [7:0] c, input int seed);
    chk(ngot == 3, req, "frame count", 24'(ngot), 24'd3);
    for (int f = 0; f < 3; f++) begin
      chk(got_l[f] == expv(l_smp(seed, f), c), req, $sformatf("left %0d", f),
          got_l[f], expv(l_smp(seed, f), c));
      chk(got_r[f] == expv(r_smp(seed, f), c), req, $sformatf("right %0d", f),
          got_r[f], expv(r_smp(seed, f), c));
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    cfg   = 8'h80;
    repeat (3) @(negedge clk);
    chk(left_o == 0, "R10", "left_o", left_o, 24'd0);
    chk(right_o == 0, "R10", "right_o", right_o, 24'd0);
    chk(valid_o == 0, "R10", "valid_o", 24'(valid_o), 24'd0);
    chk(sclk_o == 0 && lrck_o == 0, "R10", "clock outs", {22'd0, sclk_o, lrck_o}, 24'd0);
  endtask

  task automatic run_slave(input string req, input logic [7:0] c, input int seed);
    int n;
    do_reset(c);
    n = c[6] ? 64 : 32;
    send_bit(c, c[0], 1'b1);
    send_bit(c, c[0], 1'b1);
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < n; i++) send_bit(c, ~c[0], fbit(l_smp(seed, f), i, c));
      for (int i = 0; i < n; i++) send_bit(c, c[0], fbit(r_smp(seed, f), i, c));
    end
    repeat (10) @(negedge clk);
    check_frames(req, c, seed);
    chk(sclk_o == 0 && lrck_o == 0, "R1", "clock outs in slave mode",
        {22'd0, sclk_o, lrck_o}, 24'd0);
  endtask

  task automatic run_master(input string req, input logic [7:0] c, input int seed);
    int   n, idx, halves, since_s, since_l, bad_per, bad_half;
    bit   s_seen, l_seen;
    logic prev_s, prev_l;
    do_reset(c);
    n = c[6] ? 64 : 32;
    idx = 0; halves = -1; since_s = 0; since_l = 0; bad_per = 0; bad_half = 0;
    s_seen = 0; l_seen = 0;
    prev_s = sclk_o; prev_l = lrck_o;
    sdata_i = 1'b1;
    while (halves < 6) begin
      @(negedge clk);
      since_s++;
      since_l++;
      if (lrck_o != prev_l) begin
        if (l_seen && since_l != n * 2 * DIV) bad_half++;
        l_seen  = 1;
        since_l = 0;
      end
      if (sclk_o != prev_s) begin
        if (sclk_o == ~c[1]) begin
          if (s_seen && since_s != 2 * DIV) bad_per++;
          s_seen  = 1;
          since_s = 0;
        end else begin
          if (lrck_o != prev_l) begin
            idx = 0;
            if (halves < 0) begin
              if (lrck_o == ~c[0]) halves = 0;
            end else begin
              halves++;
            end
          end else begin
            idx++;
          end
          if (halves >= 0 && halves < 6)
            sdata_i = fbit(halves[0] ? r_smp(seed, halves / 2) : l_smp(seed, halves / 2), idx, c);
          else
            sdata_i = 1'b1;
        end
      end
      prev_s = sclk_o;
      prev_l = lrck_o;
    end
    repeat (20) @(negedge clk);
    chk(bad_per == 0, "R1", "bit clock period errors", 24'(bad_per), 24'd0);
    chk(bad_half == 0, "R2", "word clock half-frame errors", 24'(bad_half), 24'd0);
    check_frames(req, c, seed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    test_reset();
    run_slave("R1 R4 R9", 8'h00, 1);     // LJ, 32-bit halves, rising, left high
    run_slave("R5 R11", 8'h24, 2);       // LJ, delay 1, word-length field set but ignored
    run_slave("R3 R4", 8'h08, 3);        // RJ 24
    run_slave("R2 R3 R8", 8'h58, 4);     // RJ 20, 64-bit halves
    run_slave("R6 R7 R8", 8'h2B, 5);     // RJ 16, falling edge, right high
    run_master("R1 R2 R5", 8'hC4, 6);    // driven clocks, 64-bit halves, LJ delay 1
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule